// File: doc/BRIEF.md
# Serial EEPROM Sizing Reader

This block drives a three-wire serial EEPROM of the 93C46 kind (chip select, serial clock, data toward the memory, data back from the memory). It reads the whole memory with no help from software. The part's address width is not known in advance. The first frame clocks in all-zero address bits and watches the returning data line. The memory pulls that line low right after it has taken its last address bit, so the number of bits shifted at that point is the address width. The block then reads word 0 again at the width it found, and reads every word in ascending order into an internal array. It adds the words modulo 2^16 and compares the total with a fixed signature.

A single `start` pulse begins the sequence. When `done` rises, `addr_bits`, `size_err` and `sum_ok` are valid, and any stored word can be fetched through the read port. The read port has a fixed one-cycle latency and no handshake: the array always accepts an address and always returns a word, so there is no back-pressure. The speed of the serial clock is set at run time through `half_cycles`.

Top module: `eeprom_sizer`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `done`, `size_err`, `sum_ok` are 0 and `addr_bits` is 0.
- R2: Every half period of the serial clock, and every setup and idle slot in a frame, lasts max(`half_cycles`,1) system clock cycles.
- R3: A frame opens with `ee_cs`=1 and `ee_sk`=0 for one half period. `ee_cs` then stays 1 until the data phase ends, and `ee_sk` is never 1 while `ee_cs` is 0.
- R4: After the opening slot come the read command bits 1, 1, 0. For each bit, `ee_di` holds the bit while `ee_sk` is high for one half period and then low for one half period.
- R5: The first frame shifts zero address bits, up to MAX_ABITS of them. At the end of each bit's low half, `ee_do` is sampled. A 0 ends the address phase at once, and `addr_bits` becomes the number of bits shifted so far.
- R6: If `ee_do` is still 1 after MAX_ABITS address bits, `size_err` is set to 1 and `addr_bits` is set to MAX_ABITS.
- R7: Sixteen data bits follow, most significant first. Each is sampled at the end of an `ee_sk` high half, and `ee_di` is 0 throughout.
- R8: After the data phase, all three serial lines are 0 for one half period. The next frame, if any, starts right after.
- R9: Frame order: the sizing frame, then word 0 again, then words 0 to 2^`addr_bits`-1 in ascending order. Each of these later frames shifts exactly `addr_bits` address bits, most significant first, with no early stop.
- R10: `done` rises at the end of the last frame's idle slot, and the lines stay 0 after that. `sum_ok` is 1 exactly when the 16-bit wrap-around sum of the stored words equals 16'hBABA.
- R11: `rd_data` gives the stored word at `rd_addr` one cycle after the address is presented.
- R12: `start` has no effect while a sequence runs. `start` when idle or done clears `done`, `sum_ok` and `size_err`, and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin sizing and a full read |
| half_cycles | input | DIV_W | Serial clock half period in system cycles (0 acts as 1) |
| ee_cs | output | 1 | Chip select to the EEPROM |
| ee_sk | output | 1 | Serial clock to the EEPROM |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| addr_bits | output | $clog2(MAX_ABITS+1) | Detected address width |
| size_err | output | 1 | No dummy zero seen while sizing |
| done | output | 1 | Sequence complete |
| sum_ok | output | 1 | Word sum matches the signature |
| rd_addr | input | MAX_ABITS | Read port address |
| rd_data | output | 16 | Read port word, one cycle latency |

## Verification
A wrong phase or bit counter shows at once on the serial lines. A command, address or data bit, or a half period, that is off by one cycle makes the pin triple differ from the expected waveform on the very cycle it goes wrong, because the pins are compared every clock. A wrong sizing result changes the length of every later frame and the count of array frames, so it shows within the second frame. It also shows in `addr_bits` once `done` is set. Faults in the stored words or in the running sum stay hidden on the pins. They appear only in `sum_ok` when the sequence ends, and in the words read back through the read port.

// File: rtl/eesz_pkg.sv
package eesz_pkg;
  localparam int WORD_W  = 16;
  localparam int CMD_LEN = 3;
  localparam logic [CMD_LEN-1:0] READ_CMD = 3'b110;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SETUP, PH_CMD_HI, PH_CMD_LO, PH_ADR_HI, PH_ADR_LO,
    PH_DAT_HI, PH_DAT_LO, PH_GAP
  } phase_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DETECT, ST_CONFIRM, ST_ARRAY, ST_DONE
  } pass_e;
endpackage

// File: rtl/eesz_tick.sv
module eesz_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cycles,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload   = (half_cycles == '0) ? '0 : half_cycles - 1'b1;
  assign half_end = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == '0) cnt <= reload;
    else                        cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/eesz_wire.sv
module eesz_wire
  import eesz_pkg::*;
#(
  parameter int MAX_ABITS = 8,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic                 go_on,
  input  logic                 detect,
  input  logic [CNT_W-1:0]     abits,
  input  logic [MAX_ABITS-1:0] addr,
  input  logic                 half_end,
  input  logic                 ee_do,
  output logic                 run,
  output logic                 frame_done,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  output logic [WORD_W-1:0]    rx_word,
  output logic [CNT_W-1:0]     shifted,
  output logic                 saw_zero
);
  localparam int BIG  = (WORD_W > MAX_ABITS) ? WORD_W : MAX_ABITS;
  localparam int BC_W = $clog2(BIG + 1);
  localparam int SH_W = BC_W + 1;

  phase_e               phase;
  logic [BC_W-1:0]      bcnt;
  logic [BC_W-1:0]      bnext;
  logic [CNT_W-1:0]     alen;
  logic [SH_W-1:0]      sh_amt;
  logic [MAX_ABITS-1:0] ash;
  logic [CMD_LEN-1:0]   csh;

  assign bnext  = bcnt + 1'b1;
  assign alen   = detect ? CNT_W'(MAX_ABITS) : abits;
  assign sh_amt = SH_W'(MAX_ABITS) - SH_W'(alen) + SH_W'(bcnt);
  assign ash    = addr << sh_amt;
  assign csh    = READ_CMD << bcnt;

  assign run        = (phase != PH_IDLE);
  assign frame_done = (phase == PH_GAP) && half_end;

  always_comb begin
    ee_cs = 1'b0;
    ee_sk = 1'b0;
    ee_di = 1'b0;
    unique case (phase)
      PH_SETUP:  ee_cs = 1'b1;
      PH_CMD_HI: begin ee_cs = 1'b1; ee_sk = 1'b1; ee_di = csh[CMD_LEN-1]; end
      PH_CMD_LO: begin ee_cs = 1'b1; ee_di = csh[CMD_LEN-1]; end
      PH_ADR_HI: begin ee_cs = 1'b1; ee_sk = 1'b1; ee_di = ash[MAX_ABITS-1]; end
      PH_ADR_LO: begin ee_cs = 1'b1; ee_di = ash[MAX_ABITS-1]; end
      PH_DAT_HI: begin ee_cs = 1'b1; ee_sk = 1'b1; end
      PH_DAT_LO: ee_cs = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bcnt     <= '0;
      rx_word  <= '0;
      shifted  <= '0;
      saw_zero <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (go) phase <= PH_SETUP;
    end else if (half_end) begin
      unique case (phase)
        PH_SETUP: begin
          phase    <= PH_CMD_HI;
          bcnt     <= '0;
          shifted  <= '0;
          saw_zero <= 1'b0;
        end
        PH_CMD_HI: phase <= PH_CMD_LO;
        PH_CMD_LO: begin
          if (bcnt == BC_W'(CMD_LEN - 1)) begin
            phase <= PH_ADR_HI;
            bcnt  <= '0;
          end else begin
            phase <= PH_CMD_HI;
            bcnt  <= bnext;
          end
        end
        PH_ADR_HI: phase <= PH_ADR_LO;
        PH_ADR_LO: begin
          shifted <= CNT_W'(bnext);
          if (detect && !ee_do) begin
            saw_zero <= 1'b1;
            phase    <= PH_DAT_HI;
            bcnt     <= '0;
          end else if (bnext == BC_W'(alen)) begin
            phase <= PH_DAT_HI;
            bcnt  <= '0;
          end else begin
            phase <= PH_ADR_HI;
            bcnt  <= bnext;
          end
        end
        PH_DAT_HI: begin
          rx_word <= {rx_word[WORD_W-2:0], ee_do};
          phase   <= PH_DAT_LO;
        end
        PH_DAT_LO: begin
          if (bcnt == BC_W'(WORD_W - 1)) phase <= PH_GAP;
          else begin
            phase <= PH_DAT_HI;
            bcnt  <= bnext;
          end
        end
        PH_GAP:  phase <= go_on ? PH_SETUP : PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eesz_store.sv
module eesz_store
  import eesz_pkg::*;
#(
  parameter int MAX_ABITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wen,
  input  logic [MAX_ABITS-1:0] waddr,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [MAX_ABITS-1:0] rd_addr,
  output logic [WORD_W-1:0]    rd_data,
  output logic [WORD_W-1:0]    sum_q
);
  localparam int DEPTH = 1 << MAX_ABITS;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sum_q <= '0;
    else if (wen)      sum_q <= sum_q + wdata;
  end
endmodule

// File: rtl/eeprom_sizer.sv
module eeprom_sizer
  import eesz_pkg::*;
#(
  parameter int               MAX_ABITS = 8,
  parameter int               DIV_W     = 8,
  parameter logic [WORD_W-1:0] SIGNATURE = 16'hBABA,
  localparam int              CNT_W     = $clog2(MAX_ABITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DIV_W-1:0]     half_cycles,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do,
  output logic [CNT_W-1:0]     addr_bits,
  output logic                 size_err,
  output logic                 done,
  output logic                 sum_ok,
  input  logic [MAX_ABITS-1:0] rd_addr,
  output logic [WORD_W-1:0]    rd_data
);
  pass_e                st;
  logic [MAX_ABITS-1:0] idx;
  logic [MAX_ABITS-1:0] last_idx;
  logic [MAX_ABITS-1:0] frame_addr;
  logic                 accept;
  logic                 go_on;
  logic                 run;
  logic                 half_end;
  logic                 frame_done;
  logic [WORD_W-1:0]    rx_word;
  logic [CNT_W-1:0]     shifted;
  logic                 saw_zero;
  logic [WORD_W-1:0]    sum_q;
  logic                 wen;

  assign accept     = start && (st == ST_IDLE || st == ST_DONE);
  assign last_idx   = {MAX_ABITS{1'b1}} >> (MAX_ABITS - int'(addr_bits));
  assign go_on      = !(st == ST_ARRAY && idx == last_idx);
  assign frame_addr = (st == ST_ARRAY) ? idx : '0;
  assign wen        = frame_done && (st == ST_ARRAY);

  eesz_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .half_cycles(half_cycles),
    .half_end(half_end)
  );

  eesz_wire #(.MAX_ABITS(MAX_ABITS), .CNT_W(CNT_W)) u_wire (
    .clk(clk), .rst_n(rst_n), .go(accept), .go_on(go_on),
    .detect(st == ST_DETECT), .abits(addr_bits), .addr(frame_addr),
    .half_end(half_end), .ee_do(ee_do), .run(run), .frame_done(frame_done),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .rx_word(rx_word),
    .shifted(shifted), .saw_zero(saw_zero)
  );

  eesz_store #(.MAX_ABITS(MAX_ABITS)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(accept), .wen(wen), .waddr(idx),
    .wdata(rx_word), .rd_addr(rd_addr), .rd_data(rd_data), .sum_q(sum_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      addr_bits <= '0;
      size_err  <= 1'b0;
      done      <= 1'b0;
      sum_ok    <= 1'b0;
    end else if (accept) begin
      st        <= ST_DETECT;
      idx       <= '0;
      addr_bits <= '0;
      size_err  <= 1'b0;
      done      <= 1'b0;
      sum_ok    <= 1'b0;
    end else if (frame_done) begin
      unique case (st)
        ST_DETECT: begin
          addr_bits <= saw_zero ? shifted : CNT_W'(MAX_ABITS);
          size_err  <= !saw_zero;
          st        <= ST_CONFIRM;
        end
        ST_CONFIRM: begin
          idx <= '0;
          st  <= ST_ARRAY;
        end
        ST_ARRAY: begin
          if (idx == last_idx) begin
            st     <= ST_DONE;
            done   <= 1'b1;
            sum_ok <= ((sum_q + rx_word) == SIGNATURE);
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end
endmodule

// File: rtl/eesz_chk.sv
module eesz_chk #(
  parameter int MAX_ABITS = 8,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [DIV_W-1:0] half_cycles,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_di,
  input logic [CNT_W-1:0] addr_bits,
  input logic             size_err,
  input logic             done
);
  logic [DIV_W:0] hi_run;
  logic [DIV_W:0] h_eff;

  assign h_eff = (half_cycles == '0) ? (DIV_W+1)'(1) : (DIV_W+1)'(half_cycles);

  always_ff @(posedge clk) begin
    if (!rst_n)     hi_run <= '0;
    else if (ee_sk) hi_run <= hi_run + 1'b1;
    else            hi_run <= '0;
  end

  AST_SK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> hi_run == h_eff); // R2
  AST_SK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_cs && !ee_sk && !ee_di)); // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10
  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (addr_bits >= CNT_W'(1) && addr_bits <= CNT_W'(MAX_ABITS))); // R5
  AST_ERR_FULL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && size_err) |-> addr_bits == CNT_W'(MAX_ABITS)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && !size_err)); // R12
endmodule

bind eeprom_sizer eesz_chk #(.MAX_ABITS(MAX_ABITS), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .half_cycles(half_cycles),
  .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .addr_bits(addr_bits),
  .size_err(size_err), .done(done)
);

// File: tb/sim_eeprom_sizer.sv
module sim_eeprom_sizer;
  localparam int CLK_P = 10;
  localparam int MAXA  = 8;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << MAXA;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [DW-1:0]   half_cycles = 8'd2;
  logic            ee_cs, ee_sk, ee_di;
  logic            ee_do;
  logic [3:0]      addr_bits;
  logic            size_err, done, sum_ok;
  logic [MAXA-1:0] rd_addr = '0;
  logic [15:0]     rd_data;

  always #(CLK_P/2) clk = ~clk;

  eeprom_sizer #(.MAX_ABITS(MAXA), .DIV_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .half_cycles(half_cycles),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do),
    .addr_bits(addr_bits), .size_err(size_err), .done(done), .sum_ok(sum_ok),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int vectors = 0;
  int misses  = 0;

  // behavioural EEPROM: acts on rising serial clock, seen at the falling system edge
  logic [15:0] rom [DEPTH];
  int          m_w = 6;
  bit          m_stuck = 1'b0;
  int          m_edges = 0;
  int          m_adr = 0;
  logic        m_prev_sk = 1'b0;
  logic        m_do = 1'b1;
  assign ee_do = m_do;

  always @(negedge clk) begin
    if (!ee_cs) begin
      m_edges = 0;
      m_adr   = 0;
      m_do    = 1'b1;
    end else if (ee_sk && !m_prev_sk) begin
      m_edges = m_edges + 1;
      if (m_edges > 3 && m_edges <= 3 + m_w) begin
        m_adr = ((m_adr << 1) | int'(ee_di)) & ((1 << m_w) - 1);
        if (m_edges == 3 + m_w && !m_stuck) m_do = 1'b0;
      end else if (m_edges > 3 + m_w && m_edges <= 19 + m_w && !m_stuck) begin
        m_do = rom[m_adr][15 - (m_edges - 4 - m_w)];
      end
    end
    m_prev_sk = ee_sk;
  end

  logic [2:0] exq [$];
  int heff = 2;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_half(input logic [2:0] v);
    for (int i = 0; i < heff; i++) exq.push_back(v);
  endtask

  // expected {cs,sk,di} of one read frame
  task automatic push_frame(input int adr, input int len);
    push_half(3'b100);
    for (int b = 2; b >= 0; b--) begin
      logic bv;
      bv = 1'((3'b110 >> b) & 1);
      push_half({2'b11, bv});
      push_half({2'b10, bv});
    end
    for (int k = len - 1; k >= 0; k--) begin
      logic bv;
      bv = 1'((adr >> k) & 1);
      push_half({2'b11, bv});
      push_half({2'b10, bv});
    end
    for (int d = 0; d < 16; d++) begin
      push_half(3'b110);
      push_half(3'b100);
    end
    push_half(3'b000);
  endtask

  task automatic run_case(input int w, input bit stuck, input int h,
                          input bit good, input bit do_reset, input bit poke);
    int n, wd, pos;
    logic [15:0] s, es;
    logic [15:0] expw [DEPTH];
    n = 1 << w;
    s = '0;
    for (int i = 0; i < n - 1; i++) begin
      rom[i] = 16'((i * 40503 + w * 911 + 7) & 16'hFFFF);
      s = s + rom[i];
    end
    rom[n-1] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
    m_w = w;
    m_stuck = stuck;
    @(negedge clk);
    half_cycles = DW'(h);
    heff = (h == 0) ? 1 : h;
    if (do_reset) begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1 lines", {ee_cs, ee_sk, ee_di}, 0);
      chk({done, size_err, sum_ok} == 3'b000, "R1 flags", {done, size_err, sum_ok}, 0);
      chk(addr_bits == 4'd0, "R1 addr_bits", addr_bits, 0);
    end
    wd = stuck ? MAXA : w;
    es = '0;
    for (int i = 0; i < (1 << wd); i++) begin
      expw[i] = stuck ? 16'hFFFF : rom[i];
      es = es + expw[i];
    end
    push_frame(0, wd);              // sizing frame, R5
    push_frame(0, wd);              // repeat of word 0, R9
    for (int i = 0; i < (1 << wd); i++) push_frame(i, wd);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    pos = 0;
    while (exq.size() > 0) begin
      logic [2:0] e;
      e = exq.pop_front();
      chk({ee_cs, ee_sk, ee_di} == e, "R2 R3 R4 R5 R7 R8 R9 R12 lines", {ee_cs, ee_sk, ee_di}, e);
      chk(!done, "R10 R12 done low while busy", done, 0);
      start = (poke && pos == 500);  // R12: ignored mid-sequence
      pos++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done, "R10 done", done, 1);
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R10 lines quiet", {ee_cs, ee_sk, ee_di}, 0);
    chk(addr_bits == 4'(wd), "R5 addr_bits", addr_bits, wd);
    chk(size_err == stuck, "R6 size_err", size_err, stuck);
    chk(sum_ok == (es == 16'hBABA), "R10 sum_ok", sum_ok, es == 16'hBABA);
    repeat (4) @(negedge clk);
    chk(done && !ee_cs, "R10 done holds", done, 1);
    for (int i = 0; i < (1 << wd); i++) begin
      rd_addr = MAXA'(i);
      @(negedge clk);
      chk(rd_data == expw[i], "R11 read port", rd_data, expw[i]);
    end
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    misses++;
    vectors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    run_case(6, 1'b0, 2, 1'b1, 1'b1, 1'b1);  // R5 R12
    run_case(8, 1'b0, 2, 1'b1, 1'b1, 1'b0);  // full width, no error
    run_case(4, 1'b0, 3, 1'b0, 1'b1, 1'b0);  // R10 bad sum, R2 other divider
    run_case(4, 1'b0, 3, 1'b1, 1'b0, 1'b0);  // R12 restart from done
    run_case(8, 1'b1, 1, 1'b0, 1'b1, 1'b0);  // R6 no dummy zero
    run_case(1, 1'b0, 0, 1'b1, 1'b1, 1'b0);  // R2 zero divider, one address bit
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule